// File: doc/BRIEF.md
# Integer ALU with Signed Compare and Immediate Preparation

This block is the combinational execute unit of a small load-store RISC core. It takes two register operands, an optional 16-bit immediate, an operation code and a 5-bit shift amount. In the same cycle it returns a 32-bit result and a zero flag. Branch logic issues a subtract and reads the zero flag to decide between equal and not-equal.

Immediate forms need no separate operations. An operand stage in front of the arithmetic replaces the second register operand with the extended immediate. The immediate is sign-extended for add, subtract and compare, and zero-extended for the bitwise operations. Subtracting a constant X is therefore written as an add of the immediate -X.

The signed less-than result is a 0/1 word, not a set of flags. It stays correct when the internal subtraction overflows. Add and subtract wrap modulo 2^32 and raise no exception.

Top module: `alu_core`

## Requirements
- R1: With op_sel = 0 (add), result is (src_a + operand B) modulo 2^32, with no exception on carry or overflow.
- R2: With op_sel = 1 (subtract), result is (src_a - operand B) modulo 2^32.
- R3: op_sel = 2 gives bitwise AND, 3 gives bitwise OR, and 4 gives NOR, the bitwise inverse of (src_a OR operand B).
- R4: With op_sel = 5 (set-less-than), result is 32'd1 when src_a is less than operand B as signed two's complement values, and 32'd0 otherwise. This holds even when src_a - operand B overflows.
- R5: op_sel = 6 shifts src_a left by shamt (0..31), and op_sel = 7 shifts it right by shamt. Both fill the vacated positions with zeros.
- R6: When use_imm = 1 and op_sel is 0, 1 or 5, operand B is imm_val sign-extended from bit 15. For example, imm 0xFFF6 added to 25 gives 15.
- R7: When use_imm = 1 and op_sel is 2, 3 or 4, operand B is imm_val zero-extended. For example, AND with 0x0FFF keeps the low 12 bits, and 0x12345678 OR 0xFFFF gives 0x1234FFFF.
- R8: zero is 1 exactly when the 32-bit result is all zeros. A subtract of equal operands sets it.
- R9: When use_imm = 0, operand B is src_b and imm_val has no effect on result.
- R10: Shifts ignore src_b, imm_val and use_imm.
- R11: op_sel codes 8..15 are unused and give result 0 with zero = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand (register form) |
| imm_val | input | 16 | Immediate field |
| use_imm | input | 1 | Select the extended immediate as operand B |
| op_sel | input | 4 | Operation code (see R1..R11) |
| shamt | input | 5 | Shift amount |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |

## Verification
Directed vectors target the cases that tell a correct unit from a plausible wrong one:
- a wrapping add to zero;
- a borrow past zero;
- a signed compare across the sign boundary, where the subtraction overflows and a plain sign-bit test gives the wrong answer;
- the same immediate bit pattern under sign and zero extension;
- shifts by 0 and by 31.

Seeded random operands over every code, unused codes included, then show whether any operation leaks into another's result, whether an ignored input (immediate or src_b) alters the output, and whether the zero flag follows the result.

// File: rtl/alu_pkg.sv
// Shared operation codes and helpers for the integer ALU.
// Assumes a 4-bit operation select; codes above 7 are unused.
package alu_pkg;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,
        ALU_SUB = 4'd1,
        ALU_AND = 4'd2,
        ALU_OR  = 4'd3,
        ALU_NOR = 4'd4,
        ALU_SLT = 4'd5,
        ALU_SLL = 4'd6,
        ALU_SRL = 4'd7
    } alu_op_e;

    // True for operations whose immediate is zero-extended.
    function automatic logic op_is_bitwise(input logic [3:0] op);
        return (op == ALU_AND) || (op == ALU_OR) || (op == ALU_NOR);
    endfunction

endpackage

// File: rtl/alu_opnd_prep.sv
// Operand-B preparation: chooses the register operand or the extended
// immediate. Bitwise ops zero-extend; all others sign-extend.
// Assumes IMM_W < WIDTH.
module alu_opnd_prep #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] reg_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] opnd_b
);
    import alu_pkg::*;

    localparam int EXT_W = WIDTH - IMM_W;

    logic             zext;
    logic [WIDTH-1:0] imm_ext;

    // Build the extended immediate in the form the operation requires.
    always_comb begin
        zext    = op_is_bitwise(op);
        imm_ext = {{EXT_W{imm[IMM_W-1] & ~zext}}, imm};
    end

    // Select the second operand.
    always_comb begin
        opnd_b = use_imm ? imm_ext : reg_b;
    end

    // Check the extension rules on the selected operand.
    always_comb begin
        if (use_imm && op_is_bitwise(op)) begin
            assert_imm_zext_R7: assert (opnd_b[WIDTH-1:IMM_W] == '0)
                else $error("bitwise immediate not zero-extended");
        end
        if (use_imm && !op_is_bitwise(op)) begin
            assert_imm_sext_R6: assert (opnd_b[WIDTH-1:IMM_W] == {EXT_W{imm[IMM_W-1]}})
                else $error("arithmetic immediate not sign-extended");
        end
        if (!use_imm) begin
            assert_reg_pass_R9: assert (opnd_b == reg_b)
                else $error("register operand altered");
        end
    end

endmodule

// File: rtl/alu_addsub.sv
// Shared adder for add, subtract and signed less-than. Subtract inverts
// operand B and injects a carry. Less-than is the sign of the difference
// corrected by the overflow bit. Assumes WIDTH >= 2.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf,
    output logic             lt
);
    logic [WIDTH-1:0] b_x;
    logic [WIDTH:0]   wide;

    // Conditionally invert B and form the wrapped sum.
    always_comb begin
        b_x  = b ^ {WIDTH{sub}};
        wide = {1'b0, a} + {1'b0, b_x} + {{WIDTH{1'b0}}, sub};
        sum  = wide[WIDTH-1:0];
    end

    // Derive signed overflow and the corrected less-than bit.
    always_comb begin
        ovf = (a[WIDTH-1] == b_x[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        lt  = sum[WIDTH-1] ^ ovf;
    end

    // Cross-check the difference and compare against the operands.
    always_comb begin
        if (sub) begin
            assert_slt_signed_R4: assert (lt == ($signed(a) < $signed(b)))
                else $error("signed less-than wrong");
            assert_sub_wrap_R2: assert ((sum + b) == a)
                else $error("difference does not wrap");
        end else begin
            assert_add_wrap_R1: assert ((sum - b) == a)
                else $error("sum does not wrap");
        end
    end

endmodule

// File: rtl/alu_shifter.sv
// Logarithmic logical shifter. A left shift is done by reversing the
// word, shifting right and reversing back. Vacated bits are zero.
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int SH_W  = 5
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SH_W-1:0]  amt,
    input  logic             left,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] rin;
    logic [WIDTH-1:0] rout;
    logic [WIDTH-1:0] stage [SH_W+1];

    // Reverse the input word for left shifts.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
            assign rin[i] = left ? din[WIDTH-1-i] : din[i];
        end
    endgenerate

    assign stage[0] = rin;

    // Each stage shifts right by a power of two when its amount bit is set.
    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
        end
    endgenerate

    // Undo the reversal for left shifts.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
            assign rout[i] = left ? stage[SH_W][WIDTH-1-i] : stage[SH_W][i];
        end
    endgenerate

    assign dout = rout;

    // The vacated positions must hold zeros.
    always_comb begin
        if (left) begin
            assert_sll_fill_R5: assert ((dout & ((WIDTH'(1) << amt) - WIDTH'(1))) == '0)
                else $error("left shift fill not zero");
        end else begin
            assert_srl_fill_R5: assert ((dout & ~({WIDTH{1'b1}} >> amt)) == '0)
                else $error("right shift fill not zero");
        end
    end

endmodule

// File: rtl/alu_core.sv
// Top of the integer ALU. It prepares operand B, runs the adder, the
// bitwise logic and the shifter in parallel, then selects the result by
// op_sel. Purely combinational; assumes op_sel codes from alu_pkg.
module alu_core #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             use_imm,
    input  logic [3:0]       op_sel,
    input  logic [SH_W-1:0]  shamt,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    import alu_pkg::*;

    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] shifted;
    logic             ovf;
    logic             lt;
    logic             do_sub;

    alu_opnd_prep #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_prep (
        .reg_b   (src_b),
        .imm     (imm_val),
        .use_imm (use_imm),
        .op      (op_sel),
        .opnd_b  (opnd_b)
    );

    // Subtract for both the difference and the compare.
    assign do_sub = (op_sel == ALU_SUB) || (op_sel == ALU_SLT);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (src_a),
        .b   (opnd_b),
        .sub (do_sub),
        .sum (sum),
        .ovf (ovf),
        .lt  (lt)
    );

    alu_shifter #(.WIDTH(WIDTH), .SH_W(SH_W)) u_shift (
        .din  (src_a),
        .amt  (shamt),
        .left (op_sel == ALU_SLL),
        .dout (shifted)
    );

    // Select the result for the requested operation.
    always_comb begin
        unique case (op_sel)
            ALU_ADD, ALU_SUB: result = sum;
            ALU_AND:          result = src_a & opnd_b;
            ALU_OR:           result = src_a | opnd_b;
            ALU_NOR:          result = ~(src_a | opnd_b);
            ALU_SLT:          result = {{(WIDTH-1){1'b0}}, lt};
            ALU_SLL, ALU_SRL: result = shifted;
            default:          result = '0;
        endcase
    end

    // Flag an all-zero result for branch decisions.
    assign zero = (result == '0);

    // Cross-checks between the selected result and the operands.
    always_comb begin
        if (op_sel == ALU_SLT) begin
            assert_slt_word_R4: assert (result[WIDTH-1:1] == '0)
                else $error("compare result not a 0/1 word");
        end
        if (op_sel == ALU_SUB && src_a == opnd_b) begin
            assert_eq_zero_R8: assert (zero)
                else $error("equal operands did not set zero");
        end
        if (op_sel == ALU_NOR) begin
            assert_nor_R3: assert ((result & (src_a | opnd_b)) == '0)
                else $error("NOR overlaps OR");
        end
        if (op_sel > 4'd7) begin
            assert_unused_R11: assert (zero)
                else $error("unused code gave nonzero result");
        end
    end

    // ovf is consumed inside the adder's compare; keep it referenced here.
    logic unused_ovf;
    assign unused_ovf = ovf;

endmodule

// File: tb/sim_alu_core.sv
// Self-checking bench: directed corner cases and seeded random vectors.
module sim_alu_core;

    logic        clk = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [15:0] imm_val = '0;
    logic        use_imm = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        zero;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_core u0 (
        .src_a   (src_a),
        .src_b   (src_b),
        .imm_val (imm_val),
        .use_imm (use_imm),
        .op_sel  (op_sel),
        .shamt   (shamt),
        .result  (result),
        .zero    (zero)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic ui, input logic [4:0] sh);
        logic [31:0] bb;
        if (!ui)                          bb = b;
        else if (op >= 4'd2 && op <= 4'd4) bb = {16'h0000, im};
        else                              bb = {{16{im[15]}}, im};
        case (op)
            4'd0: return a + bb;
            4'd1: return a - bb;
            4'd2: return a & bb;
            4'd3: return a | bb;
            4'd4: return ~(a | bb);
            4'd5: return ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
            4'd6: return a << sh;
            4'd7: return a >> sh;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            default: return "R11";
        endcase
    endfunction

    // Apply one vector, wait half a cycle, compare result and zero flag.
    task automatic run(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic ui,
                       input logic [4:0] sh, input logic [31:0] exp);
        @(posedge clk);
        op_sel = op; src_a = a; src_b = b; imm_val = im; use_imm = ui; shamt = sh;
        @(negedge clk);
        n_chk++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s result: got %08h expected %08h", tag, result, exp);
        end
        n_chk++;
        if (zero !== (exp == 32'd0)) begin
            n_fail++;
            $display("FAIL R8 zero flag (%s): got %0b expected %0b", tag, zero, exp == 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Idle state: all inputs zero -> add of zeros.
        @(negedge clk);
        n_chk++;
        if (result !== 32'd0 || zero !== 1'b1) begin
            n_fail++;
            $display("FAIL R8 idle: got %08h/%0b expected 00000000/1", result, zero);
        end

        run("R1", 4'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h0000_0000);
        run("R1", 4'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h8000_0000);
        run("R2", 4'd1, 32'd0, 32'd1, 16'h0, 1'b0, 5'd0, 32'hFFFF_FFFF);
        run("R8", 4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 1'b0, 5'd0, 32'h0);
        run("R3", 4'd4, 32'd0, 32'd0, 16'h0, 1'b0, 5'd0, 32'hFFFF_FFFF);
        run("R3", 4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 1'b0, 5'd0, 32'hF000_F000);
        run("R4", 4'd5, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 5'd0, 32'd1);
        run("R4", 4'd5, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, 32'd0);
        run("R4", 4'd5, 32'd5, 32'd5, 16'h0, 1'b0, 5'd0, 32'd0);
        run("R5", 4'd6, 32'd1, 32'h0, 16'h0, 1'b0, 5'd31, 32'h8000_0000);
        run("R5", 4'd7, 32'h1234_5678, 32'h0, 16'h0, 1'b0, 5'd8, 32'h0012_3456);
        run("R5", 4'd6, 32'hA5A5_A5A5, 32'h0, 16'h0, 1'b0, 5'd0, 32'hA5A5_A5A5);
        run("R6", 4'd0, 32'd25, 32'h0, 16'hFFF6, 1'b1, 5'd0, 32'd15);
        run("R6", 4'd5, 32'd0, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'd0);
        run("R6", 4'd5, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'd1);
        run("R7", 4'd2, 32'hB6A4_3D9A, 32'h0, 16'h0FFF, 1'b1, 5'd0, 32'h0000_0D9A);
        run("R7", 4'd3, 32'h1234_5678, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'h1234_FFFF);
        run("R7", 4'd4, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0, 32'hFFFF_7FFF);
        run("R9", 4'd2, 32'hFFFF_FFFF, 32'h0000_00F0, 16'hFFFF, 1'b0, 5'd0, 32'h0000_00F0);
        run("R10", 4'd7, 32'h8000_0000, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 5'd4, 32'h0800_0000);
        run("R11", 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1, 1'b0, 5'd3, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  op;
            logic [31:0] a, b;
            logic [15:0] im;
            logic        ui;
            logic [4:0]  sh;
            op = 4'($urandom_range(0, 11));
            a  = $urandom();
            b  = ($urandom_range(0, 7) == 0) ? a : $urandom();
            im = 16'($urandom());
            ui = 1'($urandom());
            sh = 5'($urandom());
            run(tag_of(op), op, a, b, im, ui, sh, model(op, a, b, im, ui, sh));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule